// File: doc/BRIEF.md
# SIMD Pixel Pack and Merge Unit

This block is the pixel-formatting datapath of a SIMD media unit working on 64-bit operands. From two 64-bit sources, a 3-bit operation code and the scale field of a graphics status register, it produces one of five results:
- a 16-bit to 8-bit saturating pack;
- a 32-bit to 8-bit pack that folds its bytes into a shifted copy of the first source;
- a 32-bit to 16-bit fixed-point pack with signed saturation;
- a byte-to-halfword expand;
- a byte interleave of two 32-bit words.

Each pack lane sign-extends its input into an intermediate wide enough for the largest scale shift. It then shifts left by the scale, drops a mode-specific number of low bits and clamps to the output range.

The computation is combinational. Result and valid flag are registered, so an operation presented with `in_valid` appears on the outputs one clock later. Register file access, instruction decode and the writing of the status register belong to the surrounding pipeline. The scale port carries status-register bits [7:3].

Top module: `pxfmt_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `result` to zero and `res_valid` to 0 on the next clock edge, whatever the other inputs are.
- R2: `res_valid` equals `in_valid` of the previous cycle. When `in_valid` was 0, `result` keeps its previous value.
- R3: The 16-bit pack (op 0) uses only `scale[3:0]`. The fixed-point pack (op 2) and the 32-bit pack (op 1) use all five bits of `scale`.
- R4: For op 0, each signed 16-bit lane i of `src_b` is shifted left by the scale and arithmetically shifted right by 7. It is then clamped to 0..255 and written to `result[8i+7:8i]`, with `result[63:32]` zero.
- R5: For op 1, each signed 32-bit half i of `src_b` is shifted left by the scale and arithmetically shifted right by 23. It is then clamped to 0..255 and written to byte 0 of result half i.
- R6: For op 1, every byte of `result` other than bytes 0 and 4 equals `src_a` shifted left by 8 bits.
- R7: For op 2, each signed 32-bit half i of `src_b` is shifted left by the scale and arithmetically shifted right by 16. It is then saturated to -32768..32767 and written as two's complement to `result[16i+15:16i]`, with `result[63:32]` zero.
- R8: For op 3, byte i of `src_b[31:0]` lands in `result[16i+11:16i+4]`, with the other bits of each 16-bit lane zero.
- R9: For op 4, byte i of `src_b[31:0]` lands in result byte 2i and byte i of `src_a[31:0]` in result byte 2i+1.
- R10: Op codes 5, 6 and 7 give a zero result while `res_valid` still rises.
- R11: No intermediate bit is lost at any scale. A lane of +1 shifted by 31 in op 1 clamps to 255, and a lane of -1 clamps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation: 0 pack16, 1 pack32, 2 fixed pack, 3 expand, 4 merge |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| scale | input | SCALE_W (5) | Scale field, status bits [7:3] |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Registered result |

## Verification
The bench builds the unit with its default `SCALE_W` of 5. Every scale value from 0 to 31 can therefore be driven, including those whose top bit the 16-bit pack must ignore. A scale of 31 on the 32-bit lanes pushes the intermediate to its full 63 significant bits, so any narrowing of the wide path shows up as a wrong clamp. Directed sources sit on both sides of each clamp bound, and random sources with idle gaps exercise the hold behaviour.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;

    localparam int DATA_W    = 64;
    localparam int HALF_W    = DATA_W / 2;
    localparam int BYTE_W    = 8;
    localparam int HWORD_W   = 16;
    localparam int P16_LANES = DATA_W / HWORD_W;
    localparam int P32_LANES = DATA_W / HALF_W;
    localparam int WEAVE_N   = HALF_W / BYTE_W;

    // fractional bits dropped by each pack mode
    localparam int DROP_P16  = 7;
    localparam int DROP_P32  = 23;
    localparam int DROP_FIX  = 16;

    typedef enum logic [2:0] {
        OP_PACK16  = 3'd0,
        OP_PACK32  = 3'd1,
        OP_PACKFIX = 3'd2,
        OP_EXPAND  = 3'd3,
        OP_MERGE   = 3'd4
    } pxfmt_op_e;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } pxfmt_state_t;

endpackage

// File: rtl/pxfmt_scale_lane.sv
module pxfmt_scale_lane #(
    parameter int IN_W       = 16,
    parameter int SHIFT_W    = 4,
    parameter int DROP       = 7,
    parameter int OUT_W      = 8,
    parameter bit OUT_SIGNED = 1'b0
) (
    input  logic [IN_W-1:0]    lane_in,
    input  logic [SHIFT_W-1:0] shamt,
    output logic [OUT_W-1:0]   lane_out
);

    // wide enough that the largest shift keeps every significant bit
    localparam int WIDE_W = IN_W + (1 << SHIFT_W);
    localparam int HI_I   = OUT_SIGNED ? (1 << (OUT_W - 1)) - 1 : (1 << OUT_W) - 1;
    localparam int LO_I   = OUT_SIGNED ? -(1 << (OUT_W - 1)) : 0;
    localparam logic signed [WIDE_W-1:0] HI_W = WIDE_W'(HI_I);
    localparam logic signed [WIDE_W-1:0] LO_W = WIDE_W'(LO_I);

    logic signed [WIDE_W-1:0] ext_w;
    logic signed [WIDE_W-1:0] shl_w;
    logic signed [WIDE_W-1:0] cut_w;

    always_comb begin
        ext_w = WIDE_W'($signed(lane_in));
        shl_w = ext_w <<< shamt;
        cut_w = shl_w >>> DROP;
        if (cut_w > HI_W) begin
            lane_out = HI_W[OUT_W-1:0];
        end else if (cut_w < LO_W) begin
            lane_out = LO_W[OUT_W-1:0];
        end else begin
            lane_out = cut_w[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/pxfmt_byteweave.sv
module pxfmt_byteweave #(
    parameter int N_BYTES = 4,
    parameter int BYTE_W  = 8
) (
    input  logic [N_BYTES*BYTE_W-1:0]   hi_src,
    input  logic [N_BYTES*BYTE_W-1:0]   lo_src,
    output logic [2*N_BYTES*BYTE_W-1:0] expand_o,
    output logic [2*N_BYTES*BYTE_W-1:0] merge_o
);

    localparam int PAD_W  = BYTE_W / 2;
    localparam int SLOT_W = 2 * BYTE_W;

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        // expand: byte sits four bits up inside its halfword
        assign expand_o[g*SLOT_W +: SLOT_W] =
            {{PAD_W{1'b0}}, lo_src[g*BYTE_W +: BYTE_W], {PAD_W{1'b0}}};
        // merge: second source low, first source high
        assign merge_o[g*SLOT_W +: SLOT_W] =
            {hi_src[g*BYTE_W +: BYTE_W], lo_src[g*BYTE_W +: BYTE_W]};
    end

endmodule

// File: rtl/pxfmt_unit.sv
module pxfmt_unit
    import pxfmt_pkg::*;
#(
    parameter int SCALE_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [2:0]         op_sel,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic [SCALE_W-1:0] scale,
    output logic               res_valid,
    output logic [DATA_W-1:0]  result
);

    localparam int NARROW_W = SCALE_W - 1;
    localparam logic [DATA_W-1:0] LOW_BYTE_MASK =
        {P32_LANES{{(HALF_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}}};

    pxfmt_state_t st_d, st_q;

    logic [BYTE_W-1:0]  p16_byte [P16_LANES];
    logic [BYTE_W-1:0]  p32_byte [P32_LANES];
    logic [HWORD_W-1:0] fix_half [P32_LANES];
    logic [DATA_W-1:0]  pack16_w, pack32_w, fix_w, expand_w, merge_w;

    // ---------------- 16-bit pack lanes ----------------
    for (genvar g = 0; g < P16_LANES; g++) begin : g_p16
        pxfmt_scale_lane #(
            .IN_W(HWORD_W), .SHIFT_W(NARROW_W), .DROP(DROP_P16),
            .OUT_W(BYTE_W), .OUT_SIGNED(1'b0)
        ) u_lane (
            .lane_in (src_b[g*HWORD_W +: HWORD_W]),
            .shamt   (scale[NARROW_W-1:0]),
            .lane_out(p16_byte[g])
        );
    end

    // ---------------- 32-bit and fixed-point pack lanes ----------------
    for (genvar g = 0; g < P32_LANES; g++) begin : g_p32
        pxfmt_scale_lane #(
            .IN_W(HALF_W), .SHIFT_W(SCALE_W), .DROP(DROP_P32),
            .OUT_W(BYTE_W), .OUT_SIGNED(1'b0)
        ) u_byte (
            .lane_in (src_b[g*HALF_W +: HALF_W]),
            .shamt   (scale),
            .lane_out(p32_byte[g])
        );
        pxfmt_scale_lane #(
            .IN_W(HALF_W), .SHIFT_W(SCALE_W), .DROP(DROP_FIX),
            .OUT_W(HWORD_W), .OUT_SIGNED(1'b1)
        ) u_fix (
            .lane_in (src_b[g*HALF_W +: HALF_W]),
            .shamt   (scale),
            .lane_out(fix_half[g])
        );
    end

    // ---------------- expand and merge ----------------
    pxfmt_byteweave #(
        .N_BYTES(WEAVE_N), .BYTE_W(BYTE_W)
    ) u_weave (
        .hi_src  (src_a[HALF_W-1:0]),
        .lo_src  (src_b[HALF_W-1:0]),
        .expand_o(expand_w),
        .merge_o (merge_w)
    );

    // ---------------- lane assembly ----------------
    always_comb begin
        pack16_w = '0;
        for (int i = 0; i < P16_LANES; i++) begin
            pack16_w[i*BYTE_W +: BYTE_W] = p16_byte[i];
        end
        pack32_w = (src_a << BYTE_W) & ~LOW_BYTE_MASK;
        fix_w    = '0;
        for (int i = 0; i < P32_LANES; i++) begin
            pack32_w[i*HALF_W +: BYTE_W] = pack32_w[i*HALF_W +: BYTE_W] | p32_byte[i];
            fix_w[i*HWORD_W +: HWORD_W]  = fix_half[i];
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            case (op_sel)
                OP_PACK16:  st_d.data = pack16_w;
                OP_PACK32:  st_d.data = pack32_w;
                OP_PACKFIX: st_d.data = fix_w;
                OP_EXPAND:  st_d.data = expand_w;
                OP_MERGE:   st_d.data = merge_w;
                default:    st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.vld;
    assign result    = st_q.data;

    // ---------------- assertions ----------------
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && result == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res_valid == $past(in_valid)));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(result));

    // R4
    pack16_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && op_sel == OP_PACK16))
            |-> (result[DATA_W-1:HALF_W] == '0));

    // R8
    expand_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && op_sel == OP_EXPAND))
            |-> ((result & 64'hF00F_F00F_F00F_F00F) == '0));

    // R9
    merge_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && op_sel == OP_MERGE))
            |-> (result[BYTE_W-1:0] == $past(src_b[BYTE_W-1:0])));

    // R10
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && op_sel > 3'd4))
            |-> (res_valid && result == '0));

endmodule

// File: tb/tb_pxfmt_unit.sv
`timescale 1ns/1ps
module tb_pxfmt_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op_sel;
    logic [63:0] src_a, src_b;
    logic [4:0]  scale;
    logic        res_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    string cur_tag = "R1";

    // model state
    logic        exp_vld = 1'b0;
    logic [63:0] exp_res = '0;
    string       exp_tag = "R1";

    always #10 clk = ~clk;

    pxfmt_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .scale(scale),
        .res_valid(res_valid), .result(result)
    );

    function automatic longint clampl(longint v, longint lo, longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic logic [63:0] model(logic [2:0] op, logic [63:0] a,
                                          logic [63:0] b, logic [4:0] sc);
        logic [63:0] r;
        longint v;
        r = '0;
        case (op)
            3'd0: for (int i = 0; i < 4; i++) begin
                v = longint'($signed(b[16*i +: 16]));
                v = (v <<< sc[3:0]) >>> 7;
                v = clampl(v, 0, 255);
                r[8*i +: 8] = v[7:0];
            end
            3'd1: begin
                r = (a << 8) & ~64'h0000_00FF_0000_00FF;
                for (int i = 0; i < 2; i++) begin
                    v = longint'($signed(b[32*i +: 32]));
                    v = (v <<< sc) >>> 23;
                    v = clampl(v, 0, 255);
                    r[32*i +: 8] = v[7:0];
                end
            end
            3'd2: for (int i = 0; i < 2; i++) begin
                v = longint'($signed(b[32*i +: 32]));
                v = (v <<< sc) >>> 16;
                v = clampl(v, -32768, 32767);
                r[16*i +: 16] = v[15:0];
            end
            3'd3: for (int i = 0; i < 4; i++)
                r[16*i +: 16] = {4'h0, b[8*i +: 8], 4'h0};
            3'd4: for (int i = 0; i < 4; i++) begin
                r[16*i +: 8]     = b[8*i +: 8];
                r[16*i + 8 +: 8] = a[8*i +: 8];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_vld <= 1'b0;
            exp_res <= '0;
            exp_tag <= "R1";
        end else begin
            exp_vld <= in_valid;
            if (in_valid) begin
                exp_res <= model(op_sel, src_a, src_b, scale);
                exp_tag <= cur_tag;
            end else begin
                exp_tag <= "R2";
            end
        end
    end

    task automatic compare();
        checks++;
        if (res_valid !== exp_vld) begin
            errors++;
            $display("FAIL R2: res_valid got %0b exp %0b", res_valid, exp_vld);
        end
        checks++;
        if (result !== exp_res) begin
            errors++;
            $display("FAIL %s: result got %h exp %h", exp_tag, result, exp_res);
        end
    endtask

    task automatic issue(string tag, logic [2:0] op, logic [63:0] a,
                         logic [63:0] b, logic [4:0] sc);
        cur_tag  = tag;
        in_valid = 1'b1;
        op_sel   = op;
        src_a    = a;
        src_b    = b;
        scale    = sc;
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        in_valid = 1'b0;
        op_sel   = 3'($urandom);
        src_a    = {$urandom, $urandom};
        src_b    = {$urandom, $urandom};
        scale    = 5'($urandom);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        in_valid = 1'b1;
        op_sel   = 3'd4;
        src_a    = 64'hFFFF_FFFF_FFFF_FFFF;
        src_b    = 64'h1234_5678_9ABC_DEF0;
        repeat (3) @(negedge clk);
        // R1: cleared while reset held
        checks++;
        if (res_valid !== 1'b0 || result !== 64'h0) begin
            errors++;
            $display("FAIL R1: got vld=%0b res=%h exp vld=0 res=0", res_valid, result);
        end
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        compare();
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_sel = '0;
        src_a = '0; src_b = '0; scale = '0;
        @(negedge clk);
        do_reset();

        // R3: top scale bit ignored by 16-bit pack, used by others
        issue("R3", 3'd0, 64'h0, 64'h0100_0080_0040_0001, 5'b1_0011);
        issue("R3", 3'd0, 64'h0, 64'h0100_0080_0040_0001, 5'b0_0011);
        issue("R3", 3'd2, 64'h0, 64'h0000_0100_0000_8000, 5'b1_0000);
        issue("R3", 3'd1, 64'h0, 64'h0000_1000_0000_0800, 5'b1_0001);

        // R4: 16-bit pack clamps and lanes
        issue("R4", 3'd0, 64'h0, 64'h7FFF_8000_0000_3FFF, 5'd0);
        issue("R4", 3'd0, 64'h0, 64'hFFFF_00FF_7F80_0080, 5'd1);
        issue("R4", 3'd0, 64'hDEAD_BEEF_0000_0000, 64'h0001_0002_0004_0008, 5'd15);
        for (int k = 0; k < 20; k++)
            issue("R4", 3'd0, {$urandom, $urandom}, {$urandom, $urandom}, 5'($urandom));

        // R5, R6: 32-bit pack
        issue("R5", 3'd1, 64'h0, 64'h7F80_0000_0080_0000, 5'd0);
        issue("R5", 3'd1, 64'h0, 64'h8000_0000_FFFF_FFFF, 5'd4);
        issue("R6", 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5'd0);
        issue("R6", 3'd1, 64'h0123_4567_89AB_CDEF, 64'h0100_0000_0000_0000, 5'd0);
        for (int k = 0; k < 20; k++)
            issue("R5", 3'd1, {$urandom, $urandom}, {$urandom, $urandom}, 5'($urandom));

        // R7: fixed-point pack saturation
        issue("R7", 3'd2, 64'h0, 64'h7FFF_FFFF_8000_0000, 5'd0);
        issue("R7", 3'd2, 64'h0, 64'h0001_0000_FFFF_0000, 5'd15);
        issue("R7", 3'd2, 64'h0, 64'h1234_5678_FEDC_BA98, 5'd0);
        for (int k = 0; k < 20; k++)
            issue("R7", 3'd2, {$urandom, $urandom}, {$urandom, $urandom}, 5'($urandom));

        // R8: expand
        issue("R8", 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_A5FF_0081, 5'd7);
        for (int k = 0; k < 10; k++)
            issue("R8", 3'd3, {$urandom, $urandom}, {$urandom, $urandom}, 5'($urandom));

        // R9: merge
        issue("R9", 3'd4, 64'h0000_0000_AABB_CCDD, 64'h0000_0000_1122_3344, 5'd0);
        for (int k = 0; k < 10; k++)
            issue("R9", 3'd4, {$urandom, $urandom}, {$urandom, $urandom}, 5'($urandom));

        // R10: unused codes
        issue("R10", 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'd3);
        issue("R10", 3'd6, {$urandom, $urandom}, {$urandom, $urandom}, 5'd9);
        issue("R10", 3'd7, {$urandom, $urandom}, {$urandom, $urandom}, 5'd31);

        // R11: full-scale shifts keep every bit
        issue("R11", 3'd1, 64'h0, 64'h0000_0001_FFFF_FFFF, 5'd31);
        issue("R11", 3'd1, 64'h0, 64'hFFFF_FFFF_0000_0001, 5'd31);
        issue("R11", 3'd2, 64'h0, 64'h0000_0001_FFFF_FFFF, 5'd31);
        issue("R11", 3'd0, 64'h0, 64'h0001_FFFF_7FFF_8000, 5'd15);

        // R2: random mix with idle gaps
        for (int k = 0; k < 300; k++) begin
            if ($urandom_range(0, 2) == 0) idle();
            else issue("R2", 3'($urandom), {$urandom, $urandom},
                       {$urandom, $urandom}, 5'($urandom));
        end

        // R1: reset in mid-stream
        issue("R9", 3'd4, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0);
        do_reset();
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout exp finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule